// File: doc/BRIEF.md
# Gauge Pointer Motion Profiler

The profiler drives one instrument pointer from where it stands to a commanded 12-bit microstep position. Motion is paced by a timebase tick and a velocity index: each index selects a step interval, counted in ticks and rounded up to a whole tick. The index climbs by one per microstep while there is room to speed up, is held at a programmable ceiling, and is walked back down one per microstep as the target nears. The pointer therefore arrives with the index at one and stops exactly on the target.

A new target may be loaded at any moment, including mid-move. The index never changes by more than one per step, so a target that suddenly lies closer, or behind the pointer, is handled by braking. This may overshoot. Once the index reaches zero, the pointer restarts toward the new target, in the reverse direction if needed. For every position the block also presents sine and cosine coil-current magnitudes with separate sign flags, taken from a 24-microstep quadrature cycle.

The target enters on a valid/ready port. `tgt_ready` is held high at all times, so the block applies no back-pressure and a target is taken on every clock in which `tgt_valid` is high. The latest accepted value replaces any earlier one. The enable, ceiling index and tick are plain level inputs.

Top module: `gauge_profiler`

## Requirements
- R1: During and right after reset: pos = 0, moving = 0, step = 0, dir_up = 0, sin_mag = 0, cos_mag = 255, both sign flags 0, and tgt_ready = 1.
- R2: A target is captured on every clock edge where tgt_valid is high. One edge later, if enable is high, the pointer is at rest and the captured target differs from pos, moving goes high and dir_up shows the travel direction (1 = increasing position).
- R3: While moving and enabled, ticks are counted from the last step, or from the start of motion. A step happens on the tick that brings the count to P(v) = ceil(64 / (v + 1)), where v is the current velocity index. Clocks without a tick do not count.
- R4: Each step raises step for exactly one clock. In that same clock pos moves by one microstep in the dir_up direction. pos changes at no other time.
- R5: After a step with distance left larger than the index, the index rises by one up to the ceiling vmax_idx, treating 0 as 1. If the ceiling has been lowered below the index, the index falls by one per step.
- R6: After a step that leaves a positive distance no larger than the index, the index falls by one, but not below one. A step that lands on the target with index one stops the pointer (moving = 0) with pos equal to the target.
- R7: The index changes by at most one per clock. After a step that reaches or passes the target with index above one, motion continues in the same direction with the index reduced by one. dir_up changes only while the pointer is at rest.
- R8: With phase = pos mod 24, quadrant q = phase / 6 and r = phase mod 6, and table M = {0,66,128,181,222,247,255}: in quadrants 0 and 2, sin_mag = M[r] and cos_mag = M[6-r]; in quadrants 1 and 3 the two are swapped. sin_neg = 1 in quadrants 2 and 3; cos_neg = 1 in quadrants 1 and 2.
- R9: While enable is low, no step is taken, no motion starts, pos holds, and the tick count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Motion enable |
| tick | input | 1 | Timebase tick, one clock wide |
| tgt_valid | input | 1 | Target word valid |
| tgt_ready | output | 1 | Target accepted (always high) |
| tgt_pos | input | 12 | Target position in microsteps |
| vmax_idx | input | 8 | Velocity index ceiling (0 acts as 1) |
| pos | output | 12 | Current microstep position |
| moving | output | 1 | Velocity index non-zero |
| step | output | 1 | One-clock pulse per microstep |
| dir_up | output | 1 | Travel direction, 1 = increasing |
| sin_mag | output | 8 | Sine coil current magnitude |
| sin_neg | output | 1 | Sine coil current negative |
| cos_mag | output | 8 | Cosine coil current magnitude |
| cos_neg | output | 1 | Cosine coil current negative |

## Verification
A short directed move at a low ceiling shows the start latency, the climb in the index and the arrival at index one. A long move at the full ceiling followed by a target flipped behind the pointer tells apart braking with overshoot from an immediate reversal. A burst with enable low shows that pos is frozen and the interval restarts. Random targets, ceilings (zero included), sparse ticks and short enable drops are compared every clock against a reference model, so slip in the tick count, the index or the coil phase shows as a mismatch in step timing, pos or coil outputs.

// File: rtl/gp_pkg.sv
package gp_pkg;
  localparam int unsigned QUAD_STEPS = 6;
  localparam int unsigned CYCLE_STEPS = 4 * QUAD_STEPS;

  function automatic logic [7:0] quad_mag(input logic [2:0] k);
    case (k)
      3'd0:    quad_mag = 8'd0;
      3'd1:    quad_mag = 8'd66;
      3'd2:    quad_mag = 8'd128;
      3'd3:    quad_mag = 8'd181;
      3'd4:    quad_mag = 8'd222;
      3'd5:    quad_mag = 8'd247;
      default: quad_mag = 8'd255;
    endcase
  endfunction
endpackage

// File: rtl/gp_step_timer.sv
module gp_step_timer #(
  parameter int VEL_W      = 8,
  parameter int PERIOD_NUM = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [VEL_W-1:0] vel,
  output logic             step_due
);
  localparam int CNT_W = $clog2(PERIOD_NUM + 1);

  logic [CNT_W-1:0] per;
  logic [CNT_W-1:0] cnt;

  // interval in ticks, rounded up: ceil(N / (v + 1))
  always_comb per = CNT_W'((PERIOD_NUM + int'(vel)) / (int'(vel) + 1));

  assign step_due = run && tick && (cnt >= per - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (tick)     cnt <= step_due ? '0 : cnt + CNT_W'(1);
  end

  // R3: the tick count never runs past the interval of the current index
  p_cnt_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < per));
endmodule

// File: rtl/gp_ramp.sv
module gp_ramp #(
  parameter int POS_W = 12,
  parameter int VEL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             step_due,
  input  logic [POS_W-1:0] tgt,
  input  logic [VEL_W-1:0] vmax,
  output logic [POS_W-1:0] pos,
  output logic [VEL_W-1:0] vel,
  output logic             dir_up,
  output logic             step
);
  localparam int AW = POS_W + 2;

  logic [VEL_W-1:0]    vceil;
  logic [AW-1:0]       np_u, left_u;
  logic signed [AW-1:0] left;

  always_comb begin
    vceil  = (vmax == '0) ? VEL_W'(1) : vmax;
    np_u   = dir_up ? AW'(pos) + AW'(1) : AW'(pos) - AW'(1);
    left_u = dir_up ? AW'(tgt) - np_u : np_u - AW'(tgt);
    left   = $signed(left_u);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      vel    <= '0;
      dir_up <= 1'b0;
      step   <= 1'b0;
    end else begin
      step <= 1'b0;
      if (step_due) begin
        pos  <= np_u[POS_W-1:0];
        step <= 1'b1;
        if (left <= 0)
          vel <= vel - VEL_W'(1);                       // reached or passed: brake
        else if (left <= $signed(AW'(vel)))
          vel <= (vel > VEL_W'(1)) ? vel - VEL_W'(1) : VEL_W'(1);
        else if (vel < vceil)
          vel <= vel + VEL_W'(1);
        else if (vel > vceil)
          vel <= vel - VEL_W'(1);
      end else if (enable && vel == '0 && tgt != pos) begin
        dir_up <= (tgt > pos);
        vel    <= VEL_W'(1);
      end
    end
  end

  // R4: a step moves the pointer by exactly one microstep
  p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> ((pos == POS_W'($past(pos) + POS_W'(1))) ||
              (pos == POS_W'($past(pos) - POS_W'(1)))));
  // R4: position never moves without a step pulse
  p_pos_on_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != $past(pos)) |-> step);
  // R7: index slews by at most one per clock
  p_vel_slew_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vel == $past(vel)) || (vel == VEL_W'($past(vel) + VEL_W'(1))) ||
    (vel == VEL_W'($past(vel) - VEL_W'(1))));
  // R7: direction flips only from rest
  p_turn_at_rest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_up != $past(dir_up)) |-> ($past(vel) == '0));
  // R5: the index climbs only on a step (apart from the start from rest)
  p_climb_on_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((vel > $past(vel)) && ($past(vel) != '0)) |-> step);
endmodule

// File: rtl/gp_coil_map.sv
module gp_coil_map #(
  parameter int POS_W = 12
) (
  input  logic [POS_W-1:0] pos,
  output logic [7:0]       sin_mag,
  output logic             sin_neg,
  output logic [7:0]       cos_mag,
  output logic             cos_neg
);
  import gp_pkg::*;

  int unsigned ph, quad, sub;
  logic        swap;

  always_comb begin
    ph      = int'(pos) % CYCLE_STEPS;
    quad    = ph / QUAD_STEPS;
    sub     = ph % QUAD_STEPS;
    swap    = quad[0];
    sin_mag = quad_mag(3'(swap ? QUAD_STEPS - sub : sub));
    cos_mag = quad_mag(3'(swap ? sub : QUAD_STEPS - sub));
    sin_neg = quad[1];
    cos_neg = quad[1] ^ quad[0];
  end

  // R8: the two coils are a quarter cycle apart: one is off exactly when the other is full
  always_comb begin
    p_quad_pair_r8: assert ((sin_mag == 8'd0) == (cos_mag == 8'd255));
  end
endmodule

// File: rtl/gauge_profiler.sv
module gauge_profiler #(
  parameter int POS_W      = 12,
  parameter int VEL_W      = 8,
  parameter int PERIOD_NUM = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic             tgt_valid,
  output logic             tgt_ready,
  input  logic [POS_W-1:0] tgt_pos,
  input  logic [VEL_W-1:0] vmax_idx,
  output logic [POS_W-1:0] pos,
  output logic             moving,
  output logic             step,
  output logic             dir_up,
  output logic [7:0]       sin_mag,
  output logic             sin_neg,
  output logic [7:0]       cos_mag,
  output logic             cos_neg
);
  logic [POS_W-1:0] tgt_q;
  logic [VEL_W-1:0] vel;
  logic             step_due;

  assign tgt_ready = 1'b1;
  assign moving    = (vel != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)         tgt_q <= '0;
    else if (tgt_valid) tgt_q <= tgt_pos;
  end

  gp_step_timer #(.VEL_W(VEL_W), .PERIOD_NUM(PERIOD_NUM)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(enable && moving), .tick(tick),
    .vel(vel), .step_due(step_due));

  gp_ramp #(.POS_W(POS_W), .VEL_W(VEL_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .enable(enable), .step_due(step_due),
    .tgt(tgt_q), .vmax(vmax_idx), .pos(pos), .vel(vel),
    .dir_up(dir_up), .step(step));

  gp_coil_map #(.POS_W(POS_W)) u_coil (
    .pos(pos), .sin_mag(sin_mag), .sin_neg(sin_neg),
    .cos_mag(cos_mag), .cos_neg(cos_neg));

  // R9: with enable low the pointer does not move on the next edge
  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(pos));
  // R2: motion starts only when enabled
  p_start_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(moving) |-> $past(enable));
endmodule

// File: tb/gauge_profiler_bench.sv
module gauge_profiler_bench;
  localparam int PN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, tick = 1'b0, tgt_valid = 1'b0;
  logic [11:0] tgt_pos = '0;
  logic [7:0]  vmax_idx = 8'd1;
  logic tgt_ready, moving, step, dir_up, sin_neg, cos_neg;
  logic [11:0] pos;
  logic [7:0]  sin_mag, cos_mag;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  int m_pos = 0, m_vel = 0, m_cnt = 0, m_tgt = 0;
  bit m_dir = 0, m_step = 0;

  always #5 clk = ~clk;

  gauge_profiler u_gauge_profiler (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_pos(tgt_pos),
    .vmax_idx(vmax_idx), .pos(pos), .moving(moving), .step(step),
    .dir_up(dir_up), .sin_mag(sin_mag), .sin_neg(sin_neg),
    .cos_mag(cos_mag), .cos_neg(cos_neg));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mag_of(input int k);
    case (k)
      0: return 0;   1: return 66;  2: return 128; 3: return 181;
      4: return 222; 5: return 247; default: return 255;
    endcase
  endfunction

  function automatic int exp_sin(input int p);
    int ph = p % 24; int q = ph / 6; int r = ph % 6;
    return (q == 1 || q == 3) ? mag_of(6 - r) : mag_of(r);
  endfunction
  function automatic int exp_cos(input int p);
    int ph = p % 24; int q = ph / 6; int r = ph % 6;
    return (q == 1 || q == 3) ? mag_of(r) : mag_of(6 - r);
  endfunction
  function automatic bit exp_sneg(input int p);
    return ((p % 24) / 6) >= 2;
  endfunction
  function automatic bit exp_cneg(input int p);
    int q = (p % 24) / 6;
    return (q == 1 || q == 2);
  endfunction
  function automatic int interval(input int v);
    return (PN + v) / (v + 1);
  endfunction

  // next reference state from the inputs present at the coming edge
  task automatic model_edge();
    int vc, np, left, per;
    bit run, due;
    vc  = (vmax_idx == 0) ? 1 : int'(vmax_idx);
    run = enable && (m_vel != 0);
    per = interval(m_vel);
    due = run && tick && (m_cnt >= per - 1);
    m_step = 0;
    if (!run) m_cnt = 0;
    else if (tick) m_cnt = due ? 0 : m_cnt + 1;
    if (due) begin
      np   = m_dir ? m_pos + 1 : m_pos - 1;
      left = m_dir ? m_tgt - np : np - m_tgt;
      m_pos = np; m_step = 1;
      if (left <= 0) m_vel = m_vel - 1;
      else if (left <= m_vel) m_vel = (m_vel > 1) ? m_vel - 1 : 1;
      else if (m_vel < vc) m_vel = m_vel + 1;
      else if (m_vel > vc) m_vel = m_vel - 1;
    end else if (enable && m_vel == 0 && m_tgt != m_pos) begin
      m_dir = (m_tgt > m_pos);
      m_vel = 1;
    end
    if (tgt_valid) m_tgt = int'(tgt_pos);
  endtask

  task automatic compare();
    check(int'(pos) == m_pos, "R4 pos", int'(pos), m_pos);
    check(step == m_step, "R3 step timing", int'(step), int'(m_step));
    check(moving == (m_vel != 0), "R5/R6 moving", int'(moving), int'(m_vel != 0));
    check(dir_up == m_dir, "R7 dir_up", int'(dir_up), int'(m_dir));
    check(int'(sin_mag) == exp_sin(int'(pos)) && int'(cos_mag) == exp_cos(int'(pos)) &&
          sin_neg == exp_sneg(int'(pos)) && cos_neg == exp_cneg(int'(pos)),
          "R8 coil", int'(sin_mag) * 256 + int'(cos_mag),
          exp_sin(int'(pos)) * 256 + exp_cos(int'(pos)));
  endtask

  // one clock: inputs are already set, advance model, sample at next falling edge
  task automatic cyc();
    model_edge();
    @(negedge clk);
    compare();
    tgt_valid = 1'b0;
  endtask

  task automatic load(input int t);
    tgt_pos = 12'(t); tgt_valid = 1'b1;
    cyc();
  endtask

  task automatic settle(input int limit);
    for (int i = 0; i < limit && (m_vel != 0 || m_pos != m_tgt); i++) cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pos == 12'd0 && !moving && !step && !dir_up, "R1 reset motion", int'(pos), 0);
    check(sin_mag == 8'd0 && cos_mag == 8'd255 && !sin_neg && !cos_neg,
          "R1 reset coil", int'(sin_mag) * 256 + int'(cos_mag), 255);
    check(tgt_ready == 1'b1, "R1 ready", int'(tgt_ready), 1);
    rst_n = 1'b1; enable = 1'b1; tick = 1'b1; vmax_idx = 8'd3;

    // R2: capture, then start one edge later
    load(30);
    check(!moving, "R2 no start before capture", int'(moving), 0);
    cyc();
    check(moving && dir_up, "R2 start up", int'(moving) * 2 + int'(dir_up), 3);
    settle(5000);
    check(int'(pos) == 30 && !moving, "R6 stop on target", int'(pos), 30);
    // R8 phase 6 -> quadrant 1, r 0
    check(sin_mag == 8'd255 && cos_mag == 8'd0 && !sin_neg && cos_neg,
          "R8 quadrant one", int'(sin_mag), 255);

    // R9 enable low freezes the pointer mid-move
    vmax_idx = 8'd20;
    load(400);
    repeat (200) cyc();
    enable = 1'b0;
    cyc();
    held = int'(pos);
    repeat (60) cyc();
    check(int'(pos) == held && !step, "R9 frozen", int'(pos), held);
    enable = 1'b1;

    // R7 full ceiling, then target flipped behind the pointer
    vmax_idx = 8'd255;
    load(2000);
    repeat (900) cyc();
    load(int'(pos) - 3);
    repeat (5) cyc();
    check(dir_up == 1'b1, "R7 brake keeps direction", int'(dir_up), 1);
    settle(20000);
    check(int'(pos) == m_tgt && !moving && !dir_up, "R7 reversed to target", int'(pos), m_tgt);

    // R5 ceiling 0 behaves as 1; one-step move
    vmax_idx = 8'd0;
    load(int'(pos) + 5);
    settle(5000);
    check(int'(pos) == m_tgt && !moving, "R5 zero ceiling reaches target", int'(pos), m_tgt);
    load(int'(pos) - 1);
    settle(500);
    check(int'(pos) == m_tgt && !moving, "R6 single step", int'(pos), m_tgt);

    // random traffic
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 60000; i++) begin
      tick = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 2999) == 0) enable = 1'b0;
      else if (!enable && $urandom_range(0, 19) == 0) enable = 1'b1;
      if ($urandom_range(0, 1999) == 0) vmax_idx = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 2499) == 0) begin
        tgt_valid = 1'b1;
        if ($urandom_range(0, 1) == 0) tgt_pos = 12'($urandom_range(0, 4095));
        else tgt_pos = 12'(int'(pos) + $urandom_range(0, 40) - 20 < 0 ? 0 :
                           (int'(pos) + 20 > 4095 ? 4095 : int'(pos) + $urandom_range(0, 40) - 20));
      end
      cyc();
    end
    enable = 1'b1; tick = 1'b1; vmax_idx = 8'd255;
    settle(60000);
    check(int'(pos) == m_tgt && !moving, "R6 random final", int'(pos), m_tgt);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule